// File: doc/BRIEF.md
# Bit-Dependent Duty-Cycle Pulse Modulator

This block turns a serial code word into the pulse train of an infrared remote transmitter. Each code bit picks a symbol. The symbol's length and the place of its single high tick both depend on that bit. The block runs on one clock at twice the symbol-clock rate, so half a symbol-clock period is one whole tick. A '1' lasts eight ticks and a '0' lasts four. In both, the output is high only in the final tick, which gives duty cycles of 1/8 and 1/4.

The block reads the bit at the output end of a code register. It holds that bit for the whole symbol. On the symbol's last tick it raises a one-tick shift request, so the register presents the next bit, and the next symbol starts on the following tick. A small rotating register, `code_ring`, is supplied as the data source. It reloads a fixed code on reset and feeds its output bit back into its far end, so the code repeats without end. While reset is high the modulated output stays high.

Top module: `pulse_modulator`

## Requirements
- R1: While `rst_i` is high, `pwm_o` is 1 and `shift_o` is 0.
- R2: A symbol that starts with `code_bit_i` = 1 lasts 8 ticks, and `pwm_o` is 1 only in its eighth tick.
- R3: A symbol that starts with `code_bit_i` = 0 lasts 4 ticks, and `pwm_o` is 1 only in its fourth tick.
- R4: Each symbol raises `shift_o` for exactly one tick, which is its final tick. The next symbol begins on the tick after that.
- R5: The bit is taken in the first tick of a symbol. A change of `code_bit_i` later in the symbol does not alter that symbol's length or the place of its high tick.
- R6: The first tick after `rst_i` falls is the first tick of a new symbol. A reset in the middle of a symbol abandons that symbol.
- R7: `code_ring` with its defaults (5 bits, preload 10010, output taken from bit 0, rotating toward bit 0 on each shift request) sends the bits 0,1,0,0,1 in that order and repeats them. Reset reloads the preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, twice the symbol-clock rate |
| rst_i | input | 1 | Synchronous active-high reset |
| code_bit_i | input | 1 | Bit at the output end of the code register |
| shift_o | output | 1 | One-tick request to advance the code register |
| pwm_o | output | 1 | Modulated output |

## Verification
The main run has the rotating code register feed the modulator for two full passes of the code. In that run, lone '1' symbols sit between '0' symbols and two '0' symbols come back to back. A symbol length that depends on the wrong bit therefore shows up as a high tick in the wrong place. A second pattern drives the data directly and flips it right after the first tick, both from 1 to 0 and from 0 to 1. This separates a design that holds the bit for the whole symbol from one that reads the bit again on every tick. A reset in the middle of a '1' symbol, followed by a fresh pass of the code, confirms that the symbol is abandoned and that the sequence starts over from its first bit.

// File: rtl/code_ring.sv
module code_ring #(
  parameter int WIDTH = 5,
  parameter logic [WIDTH-1:0] INIT = 5'b10010
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic shift_i,
  output logic bit_o
);
  logic [WIDTH-1:0] ring_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)        ring_q <= INIT;
    else if (shift_i) ring_q <= {ring_q[0], ring_q[WIDTH-1:1]};
  end

  assign bit_o = ring_q[0];
endmodule

// File: rtl/pulse_modulator.sv
module pulse_modulator #(
  parameter int ONE_TICKS  = 8,
  parameter int ZERO_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic code_bit_i,
  output logic shift_o,
  output logic pwm_o
);
  localparam int MAXT = (ONE_TICKS > ZERO_TICKS) ? ONE_TICKS : ZERO_TICKS;
  localparam int CW   = $clog2(MAXT);
  localparam logic [CW-1:0] ONE_END  = CW'(ONE_TICKS - 1);
  localparam logic [CW-1:0] ZERO_END = CW'(ZERO_TICKS - 1);

  logic [CW-1:0] pos_q;
  logic          bit_q;
  logic          first, cur_bit, last;

  assign first   = (pos_q == '0);
  assign cur_bit = first ? code_bit_i : bit_q;
  assign last    = ~rst_i & (pos_q == (cur_bit ? ONE_END : ZERO_END));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pos_q <= '0;
      bit_q <= 1'b0;
    end else begin
      if (first) bit_q <= code_bit_i;
      pos_q <= last ? '0 : pos_q + CW'(1);
    end
  end

  assign shift_o = last;
  assign pwm_o   = rst_i | last;
endmodule

// File: rtl/pulse_modulator_chk.sv
module pulse_modulator_chk #(
  parameter int ONE_TICKS  = 8,
  parameter int ZERO_TICKS = 4
) (
  input logic clk_i,
  input logic rst_i,
  input logic code_bit_i,
  input logic shift_o,
  input logic pwm_o
);
  localparam int MAXT = (ONE_TICKS > ZERO_TICKS) ? ONE_TICKS : ZERO_TICKS;

  logic [7:0] gap_q;
  logic       start_q, held_q, sym_bit;
  logic [7:0] want_end;

  assign sym_bit  = start_q ? code_bit_i : held_q;
  assign want_end = sym_bit ? 8'(ONE_TICKS - 1) : 8'(ZERO_TICKS - 1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gap_q   <= '0;
      start_q <= 1'b1;
      held_q  <= 1'b0;
    end else begin
      if (start_q) held_q <= code_bit_i;
      start_q <= shift_o;
      gap_q   <= shift_o ? 8'd0 : ((gap_q == 8'hFF) ? gap_q : gap_q + 8'd1);
    end
  end

  // R1
  reset_high_chk: assert property (@(posedge clk_i) rst_i |-> (pwm_o && !shift_o));

  // R2 R3 R5
  sym_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    shift_o |-> (gap_q == want_end));

  // R2 R3
  pwm_pos_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pwm_o |-> (gap_q == want_end));

  // R4
  pwm_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    shift_o |=> !shift_o);

  // R4
  no_overrun_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    gap_q < 8'(MAXT));
endmodule

bind pulse_modulator pulse_modulator_chk #(
  .ONE_TICKS(ONE_TICKS), .ZERO_TICKS(ZERO_TICKS)
) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .code_bit_i(code_bit_i),
  .shift_o(shift_o), .pwm_o(pwm_o)
);

// File: tb/pulse_modulator_tb_top.sv
module pulse_modulator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSYM = 10;
  localparam bit EXP_BITS [NSYM] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1,
                                     1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  logic clk = 1'b0, rst = 1'b1, use_ring = 1'b1, tb_bit = 1'b0;
  logic ring_bit, data_bit, shift, pwm;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign data_bit = use_ring ? ring_bit : tb_bit;

  code_ring ring_i (.clk_i(clk), .rst_i(rst), .shift_i(shift), .bit_o(ring_bit));
  pulse_modulator dut_i (.clk_i(clk), .rst_i(rst), .code_bit_i(data_bit),
                         .shift_o(shift), .pwm_o(pwm));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic hold_reset(input int n);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      #1;
      check(pwm === 1'b1 && shift === 1'b0, "R1 reset output", {pwm, shift}, 2);
      @(negedge clk);
    end
    rst = 1'b0;
  endtask

  task automatic run_symbol(input bit b, input bit flip, input string req);
    int len = b ? 8 : 4;
    int pwm_seen = 0, sh_seen = 0;
    for (int t = 0; t < len; t++) begin
      if (flip && t == 1) tb_bit = ~tb_bit;
      #1;
      if (pwm === 1'b1) pwm_seen |= (1 << t);
      if (shift === 1'b1) sh_seen |= (1 << t);
      @(negedge clk);
    end
    check(pwm_seen == (1 << (len - 1)), req, pwm_seen, 1 << (len - 1));
    check(sh_seen == (1 << (len - 1)), "R4 shift pulse", sh_seen, 1 << (len - 1));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    finish_run();
  end

  initial begin
    hold_reset(3);
    // R7 R2 R3: ring-driven walk over two passes of the code
    for (int s = 0; s < NSYM; s++)
      run_symbol(EXP_BITS[s], 1'b0, EXP_BITS[s] ? "R2 R7 one symbol" : "R3 R7 zero symbol");

    // R6: reset in the middle of a '1' symbol, then restart from the first bit
    run_symbol(1'b0, 1'b0, "R3 before mid reset");
    for (int t = 0; t < 3; t++) @(negedge clk);
    hold_reset(2);
    for (int s = 0; s < 5; s++)
      run_symbol(EXP_BITS[s], 1'b0, "R6 R7 restart sequence");

    // R5: data flips after the first tick are ignored
    use_ring = 1'b0;
    tb_bit = 1'b1;
    hold_reset(1);
    run_symbol(1'b1, 1'b1, "R5 one held after flip");
    tb_bit = 1'b0;
    run_symbol(1'b0, 1'b1, "R5 zero held after flip");
    run_symbol(1'b1, 1'b0, "R2 one after flipped zero");

    finish_run();
  end
endmodule